// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block connects a clocked user port to an external asynchronous static RAM of 65,536 words by 16 bits. The user offers one request at a time: an address, a write flag, a two-bit lane mask and write data. The controller registers the request and drives the memory strobes for a fixed number of clock cycles. For a read, it returns the selected lanes in a registered data word. When an access finishes, a completion pulse lasts one clock.

The memory side uses active-low chip, write and output enables and two active-low byte enables. The data bus is split into an output vector, a drive enable and an input vector, and the pad ring joins them. Two parameters set how long the strobes stay asserted, so the wait states can be matched to the speed grade of the memory. The controller never drives the bus while the memory could still be driving it. After every write strobe it holds address and data for one more cycle. When no access is in progress, the chip enable is high and the memory stays in standby.

Top module: `async_sram_ctrl`

## Requirements
- R1: While reset is asserted and right after it, chip enable, write enable, output enable and both byte enables are high, the bus drive enable is low, `rsp_done` is low and `req_ready` is high.
- R2: Whenever `req_ready` is high (no access in progress), chip enable, write enable and output enable are all high, so the memory is in standby.
- R3: A write holds chip enable and write enable low, with output enable high, for exactly WRITE_WAIT cycles. During those cycles the bus is driven with the request's write data and the address bus carries the request's address.
- R4: In the cycle after write enable returns high, the bus is still driven, and address and data are unchanged. In the cycle after that, the bus is released.
- R5: A read holds chip enable and output enable low, with write enable high and the bus released, for exactly READ_WAIT cycles. The read data is captured at the end of the last of those cycles.
- R6: Mask bit 0 selects data bits 7:0 and drives the lower byte enable `sram_lb_n` low. Mask bit 1 selects bits 15:8 and drives the upper byte enable `sram_ub_n` low. On a write, a lane that is not selected keeps its stored contents.
- R7: On a read, lanes not selected by the mask are returned as zero in `rsp_rdata`.
- R8: After every read there is one turnaround cycle. In it, output enable is high, the bus is released and `req_ready` is low, so a waiting write cannot drive the bus before the following cycle.
- R9: The bus is driven only in cycles where output enable is high in that cycle and was high in the previous cycle.
- R10: A request is accepted only when `req_ready` is high. Changes on the request inputs during an access have no effect on the address bus, the write data or the strobes.
- R11: `rsp_done` is high for exactly one cycle per access: in the write hold cycle or in the read turnaround cycle. At that point `rsp_rdata` holds the captured read word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, sampled while `req_ready` is high |
| req_ready | output | 1 | Controller idle, a request is accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_mask | input | 2 | Lane select: bit 0 = bits 7:0, bit 1 = bits 15:8 |
| req_wdata | input | 16 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Registered read data, unselected lanes zero |
| sram_addr | output | 16 | Memory address |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_lb_n | output | 1 | Lower byte enable, active low |
| sram_ub_n | output | 1 | Upper byte enable, active low |
| sram_dq_oe | output | 1 | Drive enable for the data bus |
| sram_dq_o | output | 16 | Data driven toward the memory |
| sram_dq_i | input | 16 | Data returned from the memory |

## Verification
The bench builds the controller with READ_WAIT = 3 and WRITE_WAIT = 2. Because the two values differ, a strobe-length count that takes the wrong parameter or is off by one cycle gives a visibly wrong result. The memory model returns a marker value until the last read cycle and puts a filler byte on lanes that are not enabled. Capturing data too early, or leaving an unselected lane unmasked, therefore changes the returned word. A write request held high across a read's turnaround shows whether the bus stays released for that cycle.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    localparam int SR_AW    = 16;
    localparam int SR_DW    = 16;
    localparam int SR_LANES = SR_DW / 8;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_READ  = 3'd1,
        ST_TURN  = 3'd2,
        ST_WRITE = 3'd3,
        ST_WHOLD = 3'd4
    } ctl_state_e;

    typedef struct packed {
        ctl_state_e            state;
        logic                  ce_n;
        logic                  we_n;
        logic                  oe_n;
        logic [SR_LANES-1:0]   be_n;
        logic [SR_AW-1:0]      addr;
        logic                  dq_oe;
        logic [SR_DW-1:0]      dq_o;
        logic [SR_LANES-1:0]   mask;
        logic [SR_DW-1:0]      rdata;
        logic                  done;
    } ctl_regs_t;

    function automatic ctl_regs_t ctl_reset_value();
        ctl_regs_t r;
        r.state = ST_IDLE;
        r.ce_n  = 1'b1;
        r.we_n  = 1'b1;
        r.oe_n  = 1'b1;
        r.be_n  = '1;
        r.addr  = '0;
        r.dq_oe = 1'b0;
        r.dq_o  = '0;
        r.mask  = '0;
        r.rdata = '0;
        r.done  = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/sram_wait_cnt.sv
module sram_wait_cnt #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_lane_mask.sv
module sram_lane_mask
    import sram_ctl_pkg::*;
(
    input  logic [SR_LANES-1:0] mask,
    input  logic [SR_DW-1:0]    raw,
    output logic [SR_DW-1:0]    masked
);

    for (genvar l = 0; l < SR_LANES; l++) begin : g_lane
        assign masked[l*8 +: 8] = mask[l] ? raw[l*8 +: 8] : 8'h00;
    end

endmodule

// File: rtl/async_sram_ctrl.sv
module async_sram_ctrl
    import sram_ctl_pkg::*;
#(
    parameter int READ_WAIT  = 2,
    parameter int WRITE_WAIT = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [SR_AW-1:0]    req_addr,
    input  logic [SR_LANES-1:0] req_mask,
    input  logic [SR_DW-1:0]    req_wdata,
    output logic                rsp_done,
    output logic [SR_DW-1:0]    rsp_rdata,
    output logic [SR_AW-1:0]    sram_addr,
    output logic                sram_ce_n,
    output logic                sram_we_n,
    output logic                sram_oe_n,
    output logic                sram_lb_n,
    output logic                sram_ub_n,
    output logic                sram_dq_oe,
    output logic [SR_DW-1:0]    sram_dq_o,
    input  logic [SR_DW-1:0]    sram_dq_i
);

    localparam int MAX_WAIT = (READ_WAIT > WRITE_WAIT) ? READ_WAIT : WRITE_WAIT;
    localparam int CNT_W    = $clog2(MAX_WAIT + 1);

    ctl_regs_t        s_d, s_q;
    logic             cnt_load_d;
    logic [CNT_W-1:0] cnt_val_d;
    logic             cnt_expired;
    logic [SR_DW-1:0] rd_masked;

    sram_wait_cnt #(.W(CNT_W)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load_d),
        .load_val (cnt_val_d),
        .expired  (cnt_expired)
    );

    sram_lane_mask u_lanes (
        .mask   (s_q.mask),
        .raw    (sram_dq_i),
        .masked (rd_masked)
    );

    always_comb begin
        s_d        = s_q;
        s_d.done   = 1'b0;
        cnt_load_d = 1'b0;
        cnt_val_d  = '0;
        unique case (s_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    s_d.addr   = req_addr;
                    s_d.mask   = req_mask;
                    s_d.be_n   = ~req_mask;
                    s_d.ce_n   = 1'b0;
                    cnt_load_d = 1'b1;
                    if (req_write) begin
                        s_d.state = ST_WRITE;
                        s_d.we_n  = 1'b0;
                        s_d.dq_oe = 1'b1;
                        s_d.dq_o  = req_wdata;
                        cnt_val_d = CNT_W'(WRITE_WAIT - 1);
                    end else begin
                        s_d.state = ST_READ;
                        s_d.oe_n  = 1'b0;
                        cnt_val_d = CNT_W'(READ_WAIT - 1);
                    end
                end
            end
            ST_READ: begin
                if (cnt_expired) begin
                    s_d.rdata = rd_masked;
                    s_d.done  = 1'b1;
                    s_d.ce_n  = 1'b1;
                    s_d.oe_n  = 1'b1;
                    s_d.state = ST_TURN;
                end
            end
            ST_TURN: begin
                s_d.be_n  = '1;
                s_d.state = ST_IDLE;
            end
            ST_WRITE: begin
                if (cnt_expired) begin
                    s_d.we_n  = 1'b1;
                    s_d.ce_n  = 1'b1;
                    s_d.done  = 1'b1;
                    s_d.state = ST_WHOLD;
                end
            end
            ST_WHOLD: begin
                s_d.dq_oe = 1'b0;
                s_d.be_n  = '1;
                s_d.state = ST_IDLE;
            end
            default: s_d = ctl_reset_value();
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= ctl_reset_value();
        else        s_q <= s_d;
    end

    assign req_ready  = (s_q.state == ST_IDLE);
    assign rsp_done   = s_q.done;
    assign rsp_rdata  = s_q.rdata;
    assign sram_addr  = s_q.addr;
    assign sram_ce_n  = s_q.ce_n;
    assign sram_we_n  = s_q.we_n;
    assign sram_oe_n  = s_q.oe_n;
    assign sram_lb_n  = s_q.be_n[0];
    assign sram_ub_n  = s_q.be_n[SR_LANES-1];
    assign sram_dq_oe = s_q.dq_oe;
    assign sram_dq_o  = s_q.dq_o;

    AST_STANDBY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (sram_ce_n && sram_we_n && sram_oe_n)); // R2
    AST_WE_WITH_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> (!sram_ce_n && sram_dq_oe && sram_oe_n)); // R3
    AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> (sram_dq_oe && $stable(sram_addr) && $stable(sram_dq_o))); // R4
    AST_READ_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_oe_n |-> (!sram_dq_oe && sram_we_n && !sram_ce_n)); // R5
    AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_oe_n) |-> (!sram_dq_oe && !req_ready)); // R8
    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe |-> (sram_oe_n && $past(sram_oe_n))); // R9
    AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && !$past(req_ready)) |-> $stable(sram_addr)); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done); // R11

endmodule

// File: tb/tb_async_sram_ctrl.sv
module tb_async_sram_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int RW = 3;
    localparam int WW = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [1:0]  req_mask = '0;
    logic [15:0] req_wdata = '0;
    logic        rsp_done;
    logic [15:0] rsp_rdata;
    logic [15:0] sram_addr;
    logic        sram_ce_n, sram_we_n, sram_oe_n, sram_lb_n, sram_ub_n, sram_dq_oe;
    logic [15:0] sram_dq_o;
    logic [15:0] sram_dq_i;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    async_sram_ctrl #(.READ_WAIT(RW), .WRITE_WAIT(WW)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_mask(req_mask), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n),
        .sram_oe_n(sram_oe_n), .sram_lb_n(sram_lb_n), .sram_ub_n(sram_ub_n),
        .sram_dq_oe(sram_dq_oe), .sram_dq_o(sram_dq_o), .sram_dq_i(sram_dq_i)
    );

    // Small memory model: low address byte only, lanes written when the strobe ends
    logic [15:0] mem    [256];
    logic [15:0] shadow [256];
    int          rd_cnt = 0;
    wire         wr_act = !sram_ce_n && !sram_we_n;
    wire         rd_act = !sram_ce_n && !sram_oe_n && sram_we_n;

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i]    = 16'h0000;
            shadow[i] = 16'h0000;
        end
    end

    always @(negedge wr_act) begin
        if (sram_dq_oe) begin
            if (!sram_lb_n) mem[sram_addr[7:0]][7:0]  = sram_dq_o[7:0];
            if (!sram_ub_n) mem[sram_addr[7:0]][15:8] = sram_dq_o[15:8];
        end
    end

    always @(posedge clk) begin
        if (rd_act) rd_cnt <= rd_cnt + 1;
        else        rd_cnt <= 0;
    end

    always_comb begin
        if (!rd_act)               sram_dq_i = 16'h5A5A;
        else if (rd_cnt < RW - 1)  sram_dq_i = 16'hBAD0;
        else begin
            sram_dq_i[7:0]  = !sram_lb_n ? mem[sram_addr[7:0]][7:0]  : 8'hA5;
            sram_dq_i[15:8] = !sram_ub_n ? mem[sram_addr[7:0]][15:8] : 8'hA5;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(sram_ce_n && sram_we_n && sram_oe_n, "R1", "strobes in reset",
            {sram_ce_n, sram_we_n, sram_oe_n}, 3'b111);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sram_lb_n && sram_ub_n && !sram_dq_oe, "R1", "lanes/bus after reset",
            {sram_lb_n, sram_ub_n, sram_dq_oe}, 3'b110);
        chk(req_ready && !rsp_done, "R1", "ready/done after reset",
            {req_ready, rsp_done}, 2'b10);
        chk(sram_ce_n, "R2", "standby while idle", sram_ce_n, 1);
    endtask

    task automatic t_write(input logic [15:0] a, input logic [1:0] m, input logic [15:0] d);
        int lowcnt = 0;
        logic [7:0] ix = a[7:0];
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_mask = m; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_addr = ~a; req_wdata = ~d;
        chk(!sram_ce_n && !sram_we_n && sram_oe_n, "R3", "write strobes",
            {sram_ce_n, sram_we_n, sram_oe_n}, 3'b001);
        chk(sram_dq_oe && sram_dq_o == d, "R3", "write data driven", sram_dq_o, d);
        chk(sram_addr == a, "R10", "address registered", sram_addr, a);
        chk({sram_ub_n, sram_lb_n} == ~m, "R6", "write byte enables",
            {sram_ub_n, sram_lb_n}, ~m);
        while (!sram_we_n) begin
            lowcnt++;
            @(negedge clk);
        end
        chk(lowcnt == WW, "R3", "write strobe length", lowcnt, WW);
        chk(sram_dq_oe && sram_dq_o == d && sram_addr == a, "R4", "hold after strobe",
            sram_dq_o, d);
        chk(rsp_done, "R11", "done in hold cycle", rsp_done, 1);
        @(negedge clk);
        chk(!sram_dq_oe && sram_ce_n && req_ready, "R4", "bus released after hold",
            {sram_dq_oe, sram_ce_n, req_ready}, 3'b011);
        chk(!rsp_done, "R11", "done single pulse", rsp_done, 0);
        if (m[0]) shadow[ix][7:0]  = d[7:0];
        if (m[1]) shadow[ix][15:8] = d[15:8];
    endtask

    task automatic t_read(input logic [15:0] a, input logic [1:0] m, input bit intrude);
        int lowcnt = 0;
        logic [15:0] exp;
        logic [7:0] ix = a[7:0];
        exp = {m[1] ? shadow[ix][15:8] : 8'h00, m[0] ? shadow[ix][7:0] : 8'h00};
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_mask = m;
        @(negedge clk);
        if (intrude) begin
            req_valid = 1'b1; req_write = 1'b1; req_addr = a + 16'h0001;
            req_mask = 2'b11; req_wdata = 16'hC3C3;
        end else begin
            req_valid = 1'b0;
        end
        chk(!sram_ce_n && !sram_oe_n && sram_we_n && !sram_dq_oe, "R5", "read strobes",
            {sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe}, 4'b0010);
        chk({sram_ub_n, sram_lb_n} == ~m, "R6", "read byte enables",
            {sram_ub_n, sram_lb_n}, ~m);
        while (!sram_ce_n) begin
            lowcnt++;
            if (intrude)
                chk(sram_addr == a && sram_we_n, "R10", "request ignored while busy",
                    sram_addr, a);
            @(negedge clk);
        end
        chk(lowcnt == RW, "R5", "read strobe length", lowcnt, RW);
        chk(rsp_done && rsp_rdata == exp, "R7", "read data lanes", rsp_rdata, exp);
        chk(sram_oe_n && !sram_dq_oe && !req_ready, "R8", "turnaround cycle",
            {sram_oe_n, sram_dq_oe, req_ready}, 3'b100);
        @(negedge clk);
        chk(!rsp_done, "R11", "read done single pulse", rsp_done, 0);
        chk(!sram_dq_oe && sram_we_n, "R9", "no drive in cycle after turnaround",
            {sram_dq_oe, sram_we_n}, 2'b01);
        if (intrude) begin
            @(negedge clk);
            req_valid = 1'b0;
            chk(!sram_we_n && sram_dq_oe && sram_addr == a + 16'h0001, "R10",
                "held request starts after idle", sram_addr, a + 16'h0001);
            while (!req_ready) @(negedge clk);
            shadow[ix + 8'h01] = 16'hC3C3;
        end
    endtask

    initial begin
        t_reset();
        t_write(16'h0012, 2'b11, 16'h1234);
        t_read (16'h0012, 2'b11, 1'b0);
        t_write(16'h0034, 2'b10, 16'hAB99);
        t_read (16'h0034, 2'b11, 1'b0);   // R6: lower lane stays zero
        t_read (16'h0012, 2'b01, 1'b0);   // R7: upper lane masked
        t_read (16'h0012, 2'b10, 1'b0);   // R7: lower lane masked
        t_read (16'h0012, 2'b11, 1'b1);   // R8/R10: write waiting across turnaround
        t_read (16'h0013, 2'b11, 1'b0);
        t_write(16'hFF77, 2'b01, 16'h55EE);
        t_read (16'hFF77, 2'b11, 1'b0);
        chk(sram_ce_n && sram_we_n && sram_oe_n, "R2", "standby at end",
            {sram_ce_n, sram_we_n, sram_oe_n}, 3'b111);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule